// File: doc/BRIEF.md
# Byte-Lane Strobe and Output Enable Controller

This block sits in the data path of a byte-masked synchronous DRAM interface. It turns read and write command strobes, a CAS latency selection, a per-byte mask and a clock-enable input into two per-lane controls. The first is a write enable for each byte lane. The second is an output enable for each byte lane. Command decoding and the storage arrays sit outside this block.

The write side has no latency. While a write burst is running, each lane's enable is the inverse of that lane's mask bit in the same cycle. The read side is scheduled. The output enables open a programmed number of cycles after the read command, and they stay open for one burst. A mask bit raised during a read shuts its lane two cycles later.

A low clock enable freezes every internal pipeline from the following cycle onward. Commands and mask bits that arrive during a frozen cycle are not sampled. The asynchronous reset is released through a two-stage synchronizer. After the release, the block counts as frozen for one cycle, until it has seen clock enable high.

Top module: `lane_strobe_ctrl`

## Requirements
- R1: In every active cycle of a write burst, `wr_en[i]` equals the inverse of `dqm[i]` in that same cycle. Outside a write burst, `wr_en` is 0.
- R2: An accepted write opens a burst of BURST_LEN (default 4) active cycles. The burst starts in the cycle of the command. A new write during a burst restarts the count.
- R3: An accepted read first raises the output enables after CL active cycles. `cl_sel`=0 selects CL=2 and `cl_sel`=1 selects CL=3.
- R4: The output enables stay open for exactly BURST_LEN active cycles. A read whose start falls inside a running burst extends it to BURST_LEN cycles counted from the new start.
- R5: During a read burst, `rd_oe[i]` is 0 when `dqm[i]` was high in the active cycle two active cycles earlier. Each lane follows only its own mask bit.
- R6: A cycle is active only if `cke` was high in the previous cycle. In a frozen (non-active) cycle, `wr_en` is 0, `rd_oe` keeps its value, `dqm` is not sampled, and all latency and burst pipelines hold their state.
- R7: A read or write command presented in a frozen cycle is ignored.
- R8: While reset is asserted, `wr_en` and `rd_oe` are 0, even when commands are present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke | input | 1 | Clock enable; low freezes operation from the next cycle |
| rd_cmd | input | 1 | Read command strobe |
| wr_cmd | input | 1 | Write command strobe |
| cl_sel | input | 1 | CAS latency select: 0 = 2 cycles, 1 = 3 cycles |
| dqm | input | LANES | Per-byte mask, high masks the lane |
| wr_en | output | LANES | Per-lane write enable |
| rd_oe | output | LANES | Per-lane read output enable |

## Verification
The stimulus includes writes whose mask changes every cycle. These show that the write gating is immediate and per lane, and that it ends after exactly four active cycles. Reads are issued at both latency settings. Some reads overlap, and one read carries a walking mask bit. Together these separate a one-cycle error in CAS latency from a one-cycle error in the two-cycle mask delay, and they expose any cross-lane leakage. Clock enable is dropped in the middle of a write burst, in the middle of a read latency, and just before a command. This shows that frozen cycles stretch the schedules, drop mask samples and reject commands, rather than only masking the outputs.

// File: rtl/lane_strobe_pkg.sv
package lane_strobe_pkg;
  typedef enum logic {
    CL_TWO   = 1'b0,
    CL_THREE = 1'b1
  } cas_sel_e;

  localparam int unsigned DEF_LANES      = 8;
  localparam int unsigned DEF_BURST_LEN  = 4;
  localparam int unsigned DEF_MAX_CL     = 3;
  localparam int unsigned DEF_RD_MASK_LAT = 2;
endpackage

// File: rtl/lsc_cke_gate.sv
module lsc_cke_gate (
  input  logic clk,
  input  logic rst_n_i,
  input  logic cke_i,
  output logic rst_n_o,
  output logic run_o
);
  logic [1:0] sync_q;
  logic       cke_q;
  logic       cke_d;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

  always_comb cke_d = cke_i;

  always_ff @(posedge clk or negedge rst_n_o) begin
    if (!rst_n_o) cke_q <= 1'b0;
    else          cke_q <= cke_d;
  end

  assign run_o = cke_q;
endmodule

// File: rtl/lsc_wr_gate.sv
module lsc_wr_gate #(
  parameter int unsigned LANES     = 8,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wr_cmd_i,
  input  logic [LANES-1:0] dqm_i,
  output logic [LANES-1:0] wr_en_o
);
  localparam int unsigned CW = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(BURST_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) begin
      if (wr_cmd_i)            cnt_d = LOAD;
      else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign act = run_i & (wr_cmd_i | (cnt_q != '0));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_en_o[g] = act & ~dqm_i[g];
  end

  assert_wr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && wr_cmd_i) |=> (cnt_q == LOAD));

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/lsc_mask_pipe.sv
module lsc_mask_pipe #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [LANES-1:0] dqm_i,
  output logic [LANES-1:0] mask_o
);
  logic [LANES-1:0] stg_q [DEPTH];
  logic [LANES-1:0] stg_d [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_comb stg_d[s] = run_i ? dqm_i : stg_q[s];
    end else begin : g_tail
      always_comb stg_d[s] = run_i ? stg_q[s-1] : stg_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign mask_o = stg_q[DEPTH-1];

  assert_mask_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> (stg_q[0] == $past(dqm_i)));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(mask_o));
endmodule

// File: rtl/lsc_rd_sched.sv
module lsc_rd_sched #(
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned MAX_CL    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic rd_cmd_i,
  input  logic cl_long_i,
  output logic burst_o
);
  localparam int unsigned CW = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(BURST_LEN - 1);

  logic [MAX_CL:1] dly_q, dly_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            start;

  assign start = cl_long_i ? dly_q[MAX_CL] : dly_q[MAX_CL-1];

  always_comb begin
    dly_d = dly_q;
    cnt_d = cnt_q;
    if (run_i) begin
      dly_d = {dly_q[MAX_CL-1:1], rd_cmd_i};
      if (start)              cnt_d = LOAD;
      else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      cnt_q <= '0;
    end else begin
      dly_q <= dly_d;
      cnt_q <= cnt_d;
    end
  end

  assign burst_o = start | (cnt_q != '0);

  assert_rd_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && rd_cmd_i) |=> dly_q[1]);

  assert_rd_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && start) |=> (cnt_q == LOAD));

  assert_rd_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ($stable(dly_q) && $stable(cnt_q)));
endmodule

// File: rtl/lane_strobe_ctrl.sv
module lane_strobe_ctrl
  import lane_strobe_pkg::*;
#(
  parameter int unsigned LANES       = DEF_LANES,
  parameter int unsigned BURST_LEN   = DEF_BURST_LEN,
  parameter int unsigned MAX_CL      = DEF_MAX_CL,
  parameter int unsigned RD_MASK_LAT = DEF_RD_MASK_LAT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             rd_cmd,
  input  logic             wr_cmd,
  input  logic             cl_sel,
  input  logic [LANES-1:0] dqm,
  output logic [LANES-1:0] wr_en,
  output logic [LANES-1:0] rd_oe
);
  logic             rst_n_int;
  logic             run;
  logic             burst;
  logic             cl_long;
  logic [LANES-1:0] rd_mask;

  assign cl_long = (cas_sel_e'(cl_sel) == CL_THREE);

  lsc_cke_gate u_gate (
    .clk     (clk),
    .rst_n_i (rst_n),
    .cke_i   (cke),
    .rst_n_o (rst_n_int),
    .run_o   (run)
  );

  lsc_wr_gate #(.LANES(LANES), .BURST_LEN(BURST_LEN)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .run_i    (run),
    .wr_cmd_i (wr_cmd),
    .dqm_i    (dqm),
    .wr_en_o  (wr_en)
  );

  lsc_mask_pipe #(.LANES(LANES), .DEPTH(RD_MASK_LAT)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .run_i  (run),
    .dqm_i  (dqm),
    .mask_o (rd_mask)
  );

  lsc_rd_sched #(.BURST_LEN(BURST_LEN), .MAX_CL(MAX_CL)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .run_i     (run),
    .rd_cmd_i  (rd_cmd),
    .cl_long_i (cl_long),
    .burst_o   (burst)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_oe
    assign rd_oe[g] = burst & ~rd_mask[g];
  end

  assert_oe_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    !run |=> $stable(rd_oe));

  assert_wr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    !run |-> (wr_en == '0));
endmodule

// File: tb/lane_strobe_ctrl_test.sv
module lane_strobe_ctrl_test;
  localparam int L  = 8;
  localparam int BL = 4;
  localparam int N  = 28;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, cke, rd_cmd, wr_cmd, cl_sel;
  logic [L-1:0] dqm, wr_en, rd_oe;

  lane_strobe_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .cl_sel(cl_sel), .dqm(dqm), .wr_en(wr_en), .rd_oe(rd_oe)
  );

  typedef struct {
    logic [L-1:0] wr;
    logic [L-1:0] oe;
    string        tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int errors = 0;

  logic         s_cke [N];
  logic         s_rd  [N];
  logic         s_wr  [N];
  logic [L-1:0] s_dqm [N];
  logic         s_cl;

  task automatic check(string tag, string what, logic [L-1:0] act, logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check(e.tag, "wr_en", wr_en, e.wr);
      check(e.tag, "rd_oe", rd_oe, e.oe);
    end
  end

  task automatic clear_stim(logic cl);
    for (int t = 0; t < N; t++) begin
      s_cke[t] = 1'b1; s_rd[t] = 1'b0; s_wr[t] = 1'b0; s_dqm[t] = '0;
    end
    s_cl = cl;
  endtask

  task automatic run_case(string tag);
    logic         runv [N];
    int           jx   [N];
    logic         rdk  [N];
    logic         wrk  [N];
    logic [L-1:0] dqk  [N];
    int           j, cl;
    cl = s_cl ? 3 : 2;
    j = 0;
    for (int t = 0; t < N; t++) begin
      rdk[t] = 1'b0; wrk[t] = 1'b0; dqk[t] = '0;
    end
    for (int t = 0; t < N; t++) begin
      runv[t] = (t == 0) ? 1'b1 : s_cke[t-1];
      jx[t] = j;
      if (runv[t]) begin
        rdk[j] = s_rd[t];
        wrk[j] = s_wr[t];
        dqk[j] = s_dqm[t];
        j++;
      end
    end
    for (int t = 0; t < N; t++) begin
      exp_t e;
      logic hit;
      e.tag = tag;
      e.wr  = '0;
      if (runv[t])
        for (int k = 0; k <= jx[t]; k++)
          if (wrk[k] && (jx[t] - k) < BL) e.wr = ~s_dqm[t];
      hit = 1'b0;
      for (int k = 0; k < N; k++)
        if (rdk[k] && jx[t] >= k + cl && jx[t] <= k + cl + BL - 1) hit = 1'b1;
      e.oe = hit ? ~((jx[t] >= 2) ? dqk[jx[t]-2] : '0) : '0;
      @(posedge clk); #1;
      cke = s_cke[t]; rd_cmd = s_rd[t]; wr_cmd = s_wr[t]; dqm = s_dqm[t]; cl_sel = s_cl;
      sbq.push_back(e);
    end
    @(posedge clk); #1;
    cke = 1'b1; rd_cmd = 1'b0; wr_cmd = 1'b0; dqm = '0;
    repeat (8) @(posedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; rd_cmd = 1'b1; wr_cmd = 1'b1; cl_sel = 1'b0; dqm = '0;
    repeat (3) @(negedge clk);
    check("R8", "wr_en in reset", wr_en, '0);
    check("R8", "rd_oe in reset", rd_oe, '0);
    @(posedge clk); #1;
    rd_cmd = 1'b0; wr_cmd = 1'b0;
    @(negedge clk);
    check("R8", "wr_en in reset", wr_en, '0);
    rst_n = 1'b1;
    repeat (8) @(posedge clk);
    #1;

    // R1 R2: write with a mask changing every cycle, plus masked cycle after the burst
    clear_stim(1'b0);
    s_wr[2] = 1'b1;
    s_dqm[3] = 8'h0F; s_dqm[4] = 8'hA5; s_dqm[5] = 8'h00; s_dqm[6] = 8'h3C;
    run_case("R1 R2");

    // R2: a second write inside a burst restarts it
    clear_stim(1'b0);
    s_wr[2] = 1'b1; s_wr[4] = 1'b1;
    run_case("R2");

    // R3: read at latency 2
    clear_stim(1'b0);
    s_rd[2] = 1'b1;
    run_case("R3");

    // R3 R5: read at latency 3 with masks during the burst
    clear_stim(1'b1);
    s_rd[2] = 1'b1;
    s_dqm[3] = 8'h81; s_dqm[5] = 8'h3C; s_dqm[6] = 8'hFF;
    run_case("R3 R5");

    // R4: overlapping reads extend the burst
    clear_stim(1'b0);
    s_rd[2] = 1'b1; s_rd[4] = 1'b1;
    run_case("R4");

    // R5: walking mask bit across lanes during a latency 2 read
    clear_stim(1'b0);
    s_rd[2] = 1'b1;
    for (int t = 2; t < 10; t++) s_dqm[t] = 8'h01 << (t - 2);
    run_case("R5");

    // R6: clock enable drops in the middle of a write burst
    clear_stim(1'b0);
    s_wr[2] = 1'b1;
    s_cke[3] = 1'b0; s_cke[4] = 1'b0;
    s_dqm[4] = 8'h11; s_dqm[6] = 8'h22;
    run_case("R6");

    // R6 R5: freeze during read latency; mask in frozen cycle is dropped
    clear_stim(1'b1);
    s_rd[2] = 1'b1;
    s_cke[3] = 1'b0;
    s_dqm[3] = 8'h0F; s_dqm[4] = 8'hFF; s_dqm[5] = 8'hC0;
    run_case("R6 R5");

    // R6: freeze inside a running read burst
    clear_stim(1'b0);
    s_rd[2] = 1'b1;
    s_cke[5] = 1'b0; s_cke[6] = 1'b0;
    s_dqm[4] = 8'h18;
    run_case("R6");

    // R7: commands in frozen cycles are ignored, a later one is accepted
    clear_stim(1'b0);
    s_cke[4] = 1'b0; s_rd[5] = 1'b1;
    s_cke[8] = 1'b0; s_wr[9] = 1'b1;
    s_rd[13] = 1'b1;
    run_case("R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule